// File: doc/BRIEF.md
# Edge-Triggered Delay Pulse Timer

This block watches a one-bit trigger and turns each qualifying rising edge into one delayed output pulse. Time is counted in processing intervals, marked by a one-cycle `tick` strobe; between strobes nothing inside the block moves. A delay setting selects how many intervals pass between the edge and the start of the pulse. A length setting selects how many intervals the pulse lasts. A length of zero still yields a pulse of one interval.

Once a sequence has started, the trigger has no effect until the pulse has ended. The sequence cannot be retriggered or extended. The block uses a three-state controller (idle, delaying, pulsing) and one down-counter that both phases share. The previous trigger value is held in a register that updates on every tick, so a trigger that is still high when a sequence ends does not start another one.

Top module: `edge_pulse_timer`

## Requirements
- R1: While `rst_n` is low, `pulse_out` is low and the stored previous trigger value is cleared. A trigger that is already high at the first tick after reset is therefore taken as a rising edge.
- R2: A rising edge is detected at a tick where `trig_in` is 1 and `trig_in` was 0 at the previous tick. Call this the edge tick, number k.
- R3: With delay setting X, `pulse_out` goes high in the clock cycle after tick k+X. For X = 0, this is the cycle right after the edge tick.
- R4: With length setting Y ≥ 1, `pulse_out` stays high for exactly Y tick intervals and goes low in the cycle after tick k+X+Y.
- R5: With Y = 0, `pulse_out` is high for exactly one tick interval.
- R6: While the delay or the pulse is running, `trig_in` is ignored. Edges during the run neither restart nor extend it. A trigger held high past the end of the pulse does not start a new sequence.
- R7: A rising edge detected after the pulse has ended starts a new sequence with the timing of R3 to R5.
- R8: `pulse_out` and all internal state change only on clock edges where `tick` is 1.
- R9: X is captured at the edge tick. Y is captured at the tick on which the pulse starts. Changes to either setting after its capture point have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| tick | input | 1 | Processing-interval strobe; the block advances only when it is 1 |
| trig_in | input | 1 | Trigger input, sampled on ticks |
| dly_set | input | CNT_W | Delay setting X, in ticks |
| len_set | input | CNT_W | Pulse-length setting Y, in ticks (0 behaves as 1) |
| pulse_out | output | 1 | Timed output pulse |

## Verification
The bench builds the block with `CNT_W = 4`. This makes the all-ones settings (delay 15, length 15) reachable within a short run, so the widest counter loads and the full count-down to zero are both exercised. The bench asserts `tick` once every three clocks. With idle cycles between ticks, any change outside a tick becomes visible, which is how R8 is checked.

// File: rtl/ept_pkg.sv
package ept_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } tmr_state_e;

endpackage

// File: rtl/ept_edge_det.sv
module ept_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic rise
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (tick) begin
      prev_q <= prev_d;
    end
  end

  assign rise = tick & din & ~prev_q;

endmodule

// File: rtl/ept_down_cnt.sv
module ept_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ept_ctrl.sv
module ept_ctrl
  import ept_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rise,
  input  logic         cnt_zero,
  input  logic [W-1:0] dly_set,
  input  logic [W-1:0] len_set,
  output logic         load,
  output logic [W-1:0] load_val,
  output tmr_state_e   state,
  output logic         pulse
);

  localparam logic [W-1:0] ONE = W'(1);

  tmr_state_e   state_q;
  tmr_state_e   state_d;
  logic [W-1:0] len_m1;

  always_comb begin
    len_m1 = (len_set == '0) ? '0 : (len_set - ONE);
  end

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (rise) begin
            load = 1'b1;
            if (dly_set == '0) begin
              state_d  = ST_PULSE;
              load_val = len_m1;
            end else begin
              state_d  = ST_DELAY;
              load_val = dly_set - ONE;
            end
          end
        end
        ST_DELAY: begin
          if (cnt_zero) begin
            state_d  = ST_PULSE;
            load     = 1'b1;
            load_val = len_m1;
          end
        end
        ST_PULSE: begin
          if (cnt_zero) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (tick) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
  assign pulse = (state_q == ST_PULSE);

endmodule

// File: rtl/edge_pulse_timer.sv
module edge_pulse_timer
  import ept_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] dly_set,
  input  logic [CNT_W-1:0] len_set,
  output logic             pulse_out
);

  logic             rise;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_init;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  tmr_state_e       state_q;

  ept_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .din  (trig_in),
    .rise (rise)
  );

  ept_down_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (cnt_load),
    .load_val(cnt_init),
    .cnt     (cnt_q),
    .zero    (cnt_zero)
  );

  ept_ctrl #(.W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rise    (rise),
    .cnt_zero(cnt_zero),
    .dly_set (dly_set),
    .len_set (len_set),
    .load    (cnt_load),
    .load_val(cnt_init),
    .state   (state_q),
    .pulse   (pulse_out)
  );

endmodule

// File: rtl/ept_chk.sv
module ept_chk
  import ept_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         pulse_out,
  input tmr_state_e   state,
  input logic [W-1:0] cnt
);

  localparam logic [W-1:0] ONE = W'(1);

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !pulse_out);

  p_tick_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pulse_out) && $stable(cnt)));

  p_delay_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY && tick && cnt != '0) |=> (state == ST_DELAY));

  p_pulse_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE && tick && cnt != '0) |=> pulse_out);

  p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && tick && cnt == '0) |=> !pulse_out);

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && tick && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

bind edge_pulse_timer ept_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .pulse_out(pulse_out),
  .state    (state_q),
  .cnt      (cnt_q)
);

// File: tb/edge_pulse_timer_tb_top.sv
`timescale 1ns/1ps
module edge_pulse_timer_tb_top;

  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic          trig_in;
  logic [CW-1:0] dly_set;
  logic [CW-1:0] len_set;
  logic          pulse_out;

  int checks = 0;
  int errors = 0;
  int n_ticks;
  int phase = 0;
  int rise_at = -1;
  int fall_at = -1;
  int n_rise = 0;
  int offtick = 0;
  logic p_last = 1'b0;
  logic tick_seen = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_pulse_timer #(.CNT_W(CW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .trig_in  (trig_in),
    .dly_set  (dly_set),
    .len_set  (len_set),
    .pulse_out(pulse_out)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      phase = 0;
      tick  = 1'b0;
    end else begin
      tick  = (phase == 2);
      phase = (phase == 2) ? 0 : phase + 1;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_ticks <= 0;
    else if (tick) n_ticks <= n_ticks + 1;
  end

  always @(posedge clk) tick_seen <= tick;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_out != p_last && !tick_seen) offtick++;
      if (pulse_out && !p_last) begin rise_at = n_ticks; n_rise++; end
      if (!pulse_out && p_last) fall_at = n_ticks;
    end
    p_last = pulse_out;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_tick_no(input int t);
    while (n_ticks < t) @(negedge clk);
  endtask

  task automatic wait_fall();
    while (fall_at < 0) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    trig_in = 1'b0;
    wait_tick_no(n_ticks + 2);
  endtask

  task automatic start_edge(output int e);
    @(negedge clk);
    rise_at = -1;
    fall_at = -1;
    trig_in = 1'b1;
    e = n_ticks + 1;
  endtask

  function automatic int eff_len(input int y);
    return (y == 0) ? 1 : y;
  endfunction

  // R1 and R2: reset state, and a trigger high across reset release counts as an edge
  task automatic t_reset();
    rst_n = 1'b0; trig_in = 1'b1; dly_set = 4'd2; len_set = 4'd1;
    repeat (5) @(negedge clk);
    check(pulse_out == 1'b0, "R1", "pulse_out during reset", pulse_out, 0);
    rise_at = -1; fall_at = -1;
    rst_n = 1'b1;
    wait_fall();
    check(rise_at == 3, "R1", "rise tick after reset (prev cleared)", rise_at, 3);
    check(fall_at - rise_at == 1, "R2", "pulse length after reset edge", fall_at - rise_at, 1);
  endtask

  // R3, R4, R5: plain sequences
  task automatic t_basic(input int x, input int y, input string req);
    int e;
    settle();
    dly_set = CW'(x); len_set = CW'(y);
    start_edge(e);
    wait_tick_no(e + 1);
    trig_in = 1'b0;
    wait_fall();
    check(rise_at == e + x, "R3", $sformatf("rise tick X=%0d", x), rise_at, e + x);
    check(fall_at - rise_at == eff_len(y), req, $sformatf("pulse length Y=%0d", y),
          fall_at - rise_at, eff_len(y));
  endtask

  // R6: toggling during the run changes nothing
  task automatic t_lock_toggle();
    int e;
    int last;
    int r0;
    settle();
    dly_set = 4'd6; len_set = 4'd4;
    start_edge(e);
    r0 = n_rise;
    last = e + 6 + 4 - 1;
    while (n_ticks < last) begin
      wait_tick_no(n_ticks + 1);
      if (n_ticks < last) trig_in = ~trig_in;
    end
    wait_fall();
    @(negedge clk);
    trig_in = 1'b0;
    check(rise_at == e + 6, "R6", "rise tick with toggling trigger", rise_at, e + 6);
    check(fall_at - rise_at == 4, "R6", "length with toggling trigger", fall_at - rise_at, 4);
    wait_tick_no(n_ticks + 5);
    check(n_rise - r0 == 1, "R6", "pulses from toggled run", n_rise - r0, 1);
  endtask

  // R6 held high past end, then R7 restart
  task automatic t_hold_restart();
    int e;
    int r0;
    settle();
    dly_set = 4'd2; len_set = 4'd2;
    start_edge(e);
    r0 = n_rise;
    wait_fall();
    wait_tick_no(n_ticks + 6);
    check(n_rise - r0 == 1, "R6", "pulses with trigger held high", n_rise - r0, 1);
    check(pulse_out == 1'b0, "R6", "output after held trigger", pulse_out, 0);
    @(negedge clk);
    trig_in = 1'b0;
    wait_tick_no(n_ticks + 1);
    dly_set = 4'd1; len_set = 4'd2;
    start_edge(e);
    wait_tick_no(e + 1);
    trig_in = 1'b0;
    wait_fall();
    check(rise_at == e + 1, "R7", "rise tick of restarted sequence", rise_at, e + 1);
    check(fall_at - rise_at == 2, "R7", "length of restarted sequence", fall_at - rise_at, 2);
  endtask

  // R9: capture points of X and Y
  task automatic t_capture();
    int e;
    settle();
    dly_set = 4'd4; len_set = 4'd3;
    start_edge(e);
    wait_tick_no(e + 1);
    trig_in = 1'b0;
    dly_set = 4'd12;
    len_set = 4'd2;
    while (rise_at < 0) @(negedge clk);
    len_set = 4'd9;
    wait_fall();
    check(rise_at == e + 4, "R9", "delay after X changed mid-run", rise_at, e + 4);
    check(fall_at - rise_at == 2, "R9", "length uses Y at pulse start", fall_at - rise_at, 2);
  endtask

  initial begin
    tick = 1'b0;
    t_reset();
    t_basic(0, 4, "R4");
    t_basic(5, 3, "R4");
    t_basic(3, 0, "R5");
    t_basic(0, 0, "R5");
    t_basic(15, 15, "R4");
    t_basic(1, 1, "R4");
    t_lock_toggle();
    t_hold_restart();
    t_capture();
    check(offtick == 0, "R8", "output changes away from ticks", offtick, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule